// File: doc/BRIEF.md
# Dual-Clock Retransmit FIFO

This block carries 32-bit words from one clock domain to another through a 512-entry store. The writer owns one free-running clock and the reader owns a second clock that need not be related to the first. On the read side, a prefetching output register holds the word at the head of the queue, and an output-ready flag marks that word as valid. Each side has its own fill flags, registered in its own clock domain. The writer sees input-ready and almost-full. The reader sees output-ready and almost-empty. The almost thresholds arrive as static level inputs.

The reader can also replay data. It raises a mark input while a valid word sits in the output register, and that word becomes the replay point. While mark stays high, a rewind pulse brings the marked word back onto the output and continues the read sequence from there. Storage from the mark onward is held back from the writer until mark drops, so marked data is never overwritten. Pointers pass between the domains as Gray codes through two-flop synchronisers. Every flag is therefore computed from a delayed, conservative view of the other side.

Top module: `dcf_retx_fifo`

## Requirements
- R1: While a domain's reset is high, in_ready=0, out_ready=0, almost_empty=1 and almost_full=0. After reset is released, in_ready stays 0 on the first write-clock edge and becomes 1 on the second.
- R2: A word is stored when wr_en=1 and in_ready=1 at a write-clock edge; any other write attempt has no effect. in_ready is 0 while 512 words occupy memory. Starting empty with no reads, exactly 513 words are accepted: 512 in memory plus one in the output register.
- R3: When a word is written into an empty FIFO, out_ready rises on the third read-clock edge after the write edge, and that same edge places the word on rd_data.
- R4: While out_ready=1, a new word enters the output register only at a read-clock edge with rd_en=1. If rd_en=1 arrives with no further word stored, out_ready falls. While out_ready=0, rd_en has no effect and rd_data keeps the last word.
- R5: Words appear on rd_data in write order, with none lost or duplicated.
- R6: almost_empty=1 when the read-side count (memory words plus the output-register word) is at most ae_level.
- R7: almost_full=1 when the number of free memory slots is at most af_level. A slot becomes free once its word has moved into the output register.
- R8: An edge with mark_en=1, out_ready=1 and no mark active records the current rd_data word as the mark. The mark then holds on every edge with mark_en=1 and is cleared by the first edge with mark_en=0.
- R9: With a mark active, an edge with mark_en=1 and rewind=1 puts the marked word on rd_data with out_ready=1. Later reads continue from the word written after it. Rewind takes priority over rd_en.
- R10: With a mark active, memory from the word after the mark onward is not freed by reads. in_ready falls when writes fill memory up to that point.
- R11: Pointers cross domains as Gray codes through two register stages. Each Gray pointer changes at most one bit per clock of its own domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| wrst | input | 1 | Synchronous active-high reset, write domain |
| wr_en | input | 1 | Write request |
| wr_data | input | 32 | Word to store |
| af_level | input | 9 | Almost-full threshold in free slots |
| in_ready | output | 1 | Room available for a write |
| almost_full | output | 1 | Free slots at or below af_level |
| rclk | input | 1 | Read-domain clock |
| rrst | input | 1 | Synchronous active-high reset, read domain |
| rd_en | input | 1 | Read request (consume current output word) |
| mark_en | input | 1 | Retransmit mark enable / mode hold |
| rewind | input | 1 | Return to the marked word |
| ae_level | input | 9 | Almost-empty threshold in words |
| rd_data | output | 32 | Output register contents |
| out_ready | output | 1 | rd_data holds a valid unread word |
| almost_empty | output | 1 | Stored words at or below ae_level |

## Verification
The assertions check properties that must hold on every clock. The occupancy seen by each side never exceeds 512. An asserted in_ready always means there is room. The release pointer only moves forward, one step at a time. The mark stays fixed while a mark is active, each Gray pointer flips at most one bit per cycle, and rd_data changes only while out_ready is high. The bench scenarios cover what a single-cycle property cannot express: the exact three-edge output-ready latency, the 513-word capacity, the threshold edges of both almost flags, and a replay that stalls the writer at the protected region and then delivers the marked words followed by every later word in order.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;

    localparam int PTR_MAX = 32;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_LOAD,
        RD_REWIND,
        RD_DRAIN
    } rd_action_e;

    typedef struct packed {
        logic in_ready;
        logic almost_full;
    } wr_flags_t;

    function automatic logic [PTR_MAX-1:0] to_gray(input logic [PTR_MAX-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PTR_MAX-1:0] from_gray(input logic [PTR_MAX-1:0] g);
        logic [PTR_MAX-1:0] b;
        b[PTR_MAX-1] = g[PTR_MAX-1];
        for (int i = PTR_MAX - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
module dcf_sync #(
    parameter int W      = 10,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dcf_ram.sv
`timescale 1ns/1ps
module dcf_ram #(
    parameter int AW = 9,
    parameter int DW = 32
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dcf_wctl.sv
`timescale 1ns/1ps
module dcf_wctl import dcf_pkg::*; #(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] af_level,
    input  logic [AW:0]   rel_gray_s,
    output logic [AW-1:0] waddr,
    output logic          wr_fire,
    output logic [AW:0]   wgray,
    output wr_flags_t     flags
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(1 << AW);

    logic [PW-1:0] wptr, wptr_n, rel_bin, occ_n, free_n;
    logic          live;

    assign rel_bin = PW'(from_gray(PTR_MAX'(rel_gray_s)));
    assign wr_fire = wr_en & flags.in_ready;
    assign wptr_n  = wptr + PW'(wr_fire);
    assign occ_n   = wptr_n - rel_bin;
    assign free_n  = DEPTH_P - occ_n;
    assign waddr   = wptr[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            wgray <= '0;
            live  <= 1'b0;
            flags <= '0;
        end else begin
            wptr              <= wptr_n;
            wgray             <= PW'(to_gray(PTR_MAX'(wptr_n)));
            live              <= 1'b1;
            flags.in_ready    <= live && (occ_n != DEPTH_P);
            flags.almost_full <= (free_n <= {1'b0, af_level});
        end
    end

    // R2: the writer never holds more than DEPTH words beyond the release point
    a_r2_never_overfilled: assert property (@(posedge clk) disable iff (rst)
        (PW'(wptr - rel_bin) <= DEPTH_P));

    // R2: an asserted input-ready always has a free slot behind it
    a_r2_ready_has_room: assert property (@(posedge clk) disable iff (rst)
        flags.in_ready |-> (PW'(wptr - rel_bin) < DEPTH_P));

    // R11: the write pointer code sent across changes one bit at a time
    a_r11_wgray_one_bit: assert property (@(posedge clk) disable iff (rst)
        ($countones(wgray ^ $past(wgray)) <= 1));
endmodule

// File: rtl/dcf_rctl.sv
`timescale 1ns/1ps
module dcf_rctl import dcf_pkg::*; #(
    parameter int AW = 9,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic          mark_en,
    input  logic          rewind,
    input  logic [AW-1:0] ae_level,
    input  logic [AW:0]   wgray_s,
    input  logic [DW-1:0] mem_q,
    output logic [AW-1:0] raddr,
    output logic [DW-1:0] rd_data,
    output logic          out_ready,
    output logic          almost_empty,
    output logic [AW:0]   rel_gray
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(1 << AW);

    logic [PW-1:0] wbin, rptr, rptr_n, rel, rel_n, rel_target, mark_ptr, avail, cnt_n;
    logic [DW-1:0] mark_word;
    logic          in_mode, or_n;
    rd_action_e    act;

    assign wbin  = PW'(from_gray(PTR_MAX'(wgray_s)));
    assign avail = wbin - rptr;
    assign raddr = rptr[AW-1:0];

    always_comb begin
        if (in_mode && mark_en && rewind)
            act = RD_REWIND;
        else if ((avail != '0) && (!out_ready || rd_en))
            act = RD_LOAD;
        else if (out_ready && rd_en)
            act = RD_DRAIN;
        else
            act = RD_IDLE;
    end

    always_comb begin
        rptr_n = rptr;
        or_n   = out_ready;
        unique case (act)
            RD_LOAD:   begin rptr_n = rptr + PW'(1); or_n = 1'b1; end
            RD_REWIND: begin rptr_n = mark_ptr;      or_n = 1'b1; end
            RD_DRAIN:  or_n = 1'b0;
            default:   ;
        endcase
    end

    // Release pointer walks forward one slot per cycle toward its target
    assign rel_target = in_mode ? mark_ptr : rptr;
    assign rel_n      = rel + PW'(rel != rel_target);
    assign cnt_n      = (wbin - rptr_n) + PW'(or_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr         <= '0;
            rel          <= '0;
            rel_gray     <= '0;
            out_ready    <= 1'b0;
            almost_empty <= 1'b1;
            rd_data      <= '0;
            in_mode      <= 1'b0;
            mark_ptr     <= '0;
            mark_word    <= '0;
        end else begin
            rptr         <= rptr_n;
            out_ready    <= or_n;
            rel          <= rel_n;
            rel_gray     <= PW'(to_gray(PTR_MAX'(rel_n)));
            almost_empty <= (cnt_n <= {1'b0, ae_level});
            case (act)
                RD_LOAD:   rd_data <= mem_q;
                RD_REWIND: rd_data <= mark_word;
                default:   ;
            endcase
            if (!mark_en) begin
                in_mode <= 1'b0;
            end else if (!in_mode && out_ready) begin
                in_mode   <= 1'b1;
                mark_ptr  <= rptr;
                mark_word <= rd_data;
            end
        end
    end

    // R4: the reader never sees more than DEPTH unread words
    a_r4_avail_bound: assert property (@(posedge clk) disable iff (rst)
        (PW'(wbin - rptr) <= DEPTH_P));

    // R4: the output word only changes while it is flagged valid
    a_r4_data_moves_when_ready: assert property (@(posedge clk) disable iff (rst)
        !$stable(rd_data) |-> out_ready);

    // R8: an active mark stays put
    a_r8_mark_held: assert property (@(posedge clk) disable iff (rst)
        (in_mode && $past(in_mode)) |-> ($stable(mark_ptr) && $stable(mark_word)));

    // R10: the release point never passes the mark, the mark never passes the reader
    a_r10_mark_protected: assert property (@(posedge clk) disable iff (rst)
        in_mode |-> ((PW'(rptr - mark_ptr) <= DEPTH_P) && (PW'(mark_ptr - rel) <= DEPTH_P)));

    // R11: release pointer only steps forward by at most one
    a_r11_rel_monotonic: assert property (@(posedge clk) disable iff (rst)
        (PW'(rel - $past(rel)) <= PW'(1)));

    // R11: the release code sent across changes one bit at a time
    a_r11_relgray_one_bit: assert property (@(posedge clk) disable iff (rst)
        ($countones(rel_gray ^ $past(rel_gray)) <= 1));
endmodule

// File: rtl/dcf_retx_fifo.sv
`timescale 1ns/1ps
module dcf_retx_fifo import dcf_pkg::*; #(
    parameter int AW = 9,
    parameter int DW = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic          wclk,
    input  logic          wrst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] af_level,
    output logic          in_ready,
    output logic          almost_full,
    input  logic          rclk,
    input  logic          rrst,
    input  logic          rd_en,
    input  logic          mark_en,
    input  logic          rewind,
    input  logic [AW-1:0] ae_level,
    output logic [DW-1:0] rd_data,
    output logic          out_ready,
    output logic          almost_empty
);
    localparam int PW = AW + 1;

    logic [AW-1:0] waddr, raddr;
    logic          wr_fire;
    logic [PW-1:0] wgray, wgray_s, rel_gray, rel_gray_s;
    logic [DW-1:0] mem_q;
    wr_flags_t     wflags;

    dcf_wctl #(.AW(AW)) u_wctl (
        .clk        (wclk),
        .rst        (wrst),
        .wr_en      (wr_en),
        .af_level   (af_level),
        .rel_gray_s (rel_gray_s),
        .waddr      (waddr),
        .wr_fire    (wr_fire),
        .wgray      (wgray),
        .flags      (wflags)
    );

    dcf_ram #(.AW(AW), .DW(DW)) u_ram (
        .wclk  (wclk),
        .we    (wr_fire),
        .waddr (waddr),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (mem_q)
    );

    dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_w2r (
        .clk (rclk),
        .rst (rrst),
        .d   (wgray),
        .q   (wgray_s)
    );

    dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_r2w (
        .clk (wclk),
        .rst (wrst),
        .d   (rel_gray),
        .q   (rel_gray_s)
    );

    dcf_rctl #(.AW(AW), .DW(DW)) u_rctl (
        .clk          (rclk),
        .rst          (rrst),
        .rd_en        (rd_en),
        .mark_en      (mark_en),
        .rewind       (rewind),
        .ae_level     (ae_level),
        .wgray_s      (wgray_s),
        .mem_q        (mem_q),
        .raddr        (raddr),
        .rd_data      (rd_data),
        .out_ready    (out_ready),
        .almost_empty (almost_empty),
        .rel_gray     (rel_gray)
    );

    assign in_ready    = wflags.in_ready;
    assign almost_full = wflags.almost_full;
endmodule

// File: tb/dcf_retx_fifo_test.sv
`timescale 1ns/1ps
module dcf_retx_fifo_test;
    localparam int AW = 9;
    localparam int DW = 32;

    logic          wclk = 1'b0, rclk = 1'b0;
    logic          wrst = 1'b1, rrst = 1'b1;
    logic          wr_en = 1'b0, rd_en = 1'b0, mark_en = 1'b0, rewind = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] ae_level = 9'd8, af_level = 9'd16;
    logic          in_ready, almost_full, out_ready, almost_empty;
    logic [DW-1:0] rd_data;

    int unsigned   compared = 0, mismatched = 0;
    logic [DW-1:0] hist [$];
    int            ridx = 0, mark_idx = 0;
    bit            mode_m = 1'b0;
    logic [DW-1:0] dseed = 32'h1357_2468;

    dcf_retx_fifo uut (
        .wclk (wclk), .wrst (wrst), .wr_en (wr_en), .wr_data (wr_data),
        .af_level (af_level), .in_ready (in_ready), .almost_full (almost_full),
        .rclk (rclk), .rrst (rrst), .rd_en (rd_en), .mark_en (mark_en),
        .rewind (rewind), .ae_level (ae_level), .rd_data (rd_data),
        .out_ready (out_ready), .almost_empty (almost_empty)
    );

    always #5 wclk = ~wclk;
    initial begin
        #3;
        forever #5 rclk = ~rclk;
    end

    task automatic chk(input string req, input longint act, input longint exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Reference model: write side records every accepted word
    always @(negedge wclk) begin
        if (!wrst && wr_en && in_ready) hist.push_back(wr_data);
    end

    // Reference model: read side tracks head index and replay mark
    always @(negedge rclk) begin
        int cur;
        cur = ridx;
        if (!rrst) begin
            if (out_ready) begin
                if (cur < hist.size()) chk("R5 order", rd_data, hist[cur]);
                else chk("R5 ready without data", 1, 0);
            end
            if (mode_m && mark_en && rewind) ridx = mark_idx;
            else if (rd_en && out_ready) ridx++;
            if (!mark_en) mode_m = 1'b0;
            else if (!mode_m && out_ready) begin
                mode_m   = 1'b1;
                mark_idx = cur;
            end
        end
    end

    function automatic logic [DW-1:0] next_word();
        dseed = dseed + 32'h9E37_79B9;
        return dseed;
    endfunction

    task automatic wr_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge wclk); #2;
            wr_en   = 1'b1;
            wr_data = next_word();
        end
        @(posedge wclk); #2;
        wr_en = 1'b0;
    endtask

    task automatic rd_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge rclk); #2;
            rd_en = 1'b1;
        end
        @(posedge rclk); #2;
        rd_en = 1'b0;
    endtask

    task automatic settle();
        repeat (8) @(posedge rclk);
        repeat (8) @(posedge wclk);
        @(negedge rclk);
    endtask

    task automatic traffic(input int n, input int wpct, input int rpct);
        fork
            begin
                int unsigned s = 32'h0000_1234;
                for (int i = 0; i < n; i++) begin
                    @(posedge wclk); #2;
                    s       = s * 1103515245 + 12345;
                    wr_en   = ((s >> 16) % 100) < wpct;
                    wr_data = next_word();
                end
                @(posedge wclk); #2;
                wr_en = 1'b0;
            end
            begin
                int unsigned s = 32'h0000_9876;
                for (int i = 0; i < n; i++) begin
                    @(posedge rclk); #2;
                    s     = s * 1103515245 + 12345;
                    rd_en = ((s >> 16) % 100) < rpct;
                end
                @(posedge rclk); #2;
                rd_en = 1'b0;
            end
        join
    endtask

    task automatic drain(input string req);
        settle();
        for (int i = 0; i < 5000; i++) begin
            @(posedge rclk); #2;
            rd_en = 1'b1;
            if (ridx == hist.size() && !out_ready) break;
        end
        rd_en = 1'b0;
        settle();
        chk(req, ridx, hist.size());
        chk(req, out_ready, 0);
    endtask

    initial begin
        int base, tot, n;
        logic [DW-1:0] first;

        // R1: state while held in reset
        repeat (4) @(posedge wclk); #1;
        chk("R1 in_ready in reset", in_ready, 0);
        chk("R1 out_ready in reset", out_ready, 0);
        chk("R1 almost_empty in reset", almost_empty, 1);
        chk("R1 almost_full in reset", almost_full, 0);
        @(posedge wclk); #2;
        wrst = 1'b0;
        rrst = 1'b0;
        @(posedge wclk); #1;
        chk("R1 in_ready first edge", in_ready, 0);
        @(posedge wclk); #1;
        chk("R1 in_ready second edge", in_ready, 1);

        // R3: three read-edge latency into the output register
        repeat (4) @(posedge rclk);
        @(posedge wclk); #2;
        wr_en   = 1'b1;
        wr_data = next_word();
        first   = wr_data;
        @(posedge wclk); #2;
        wr_en = 1'b0;
        @(posedge rclk); #1;
        chk("R3 out_ready edge 1", out_ready, 0);
        @(posedge rclk); #1;
        chk("R3 out_ready edge 2", out_ready, 0);
        @(posedge rclk); #1;
        chk("R3 out_ready edge 3", out_ready, 1);
        chk("R3 data on edge 3", rd_data, first);

        // R4: last word consumed, then reads while empty are ignored
        #1 rd_en = 1'b1;
        @(posedge rclk); #1;
        chk("R4 out_ready falls", out_ready, 0);
        chk("R4 data held", rd_data, first);
        repeat (3) @(posedge rclk);
        #1;
        chk("R4 read ignored when empty", rd_data, first);
        chk("R4 stays not ready", out_ready, 0);
        #1 rd_en = 1'b0;

        // R5: mixed traffic in two densities
        traffic(3000, 50, 60);
        traffic(3000, 80, 30);
        drain("R5 all delivered");

        // R2: capacity from empty with no reads
        base = hist.size();
        wr_cycles(600);
        settle();
        chk("R2 words accepted", hist.size() - base, 513);
        chk("R2 in_ready at full", in_ready, 0);
        chk("R7 almost_full at full", almost_full, 1);
        chk("R6 almost_empty at full", almost_empty, 0);

        // R7: almost-full threshold edges (af_level = 16 free slots)
        rd_cycles(16);
        settle();
        tot = hist.size() - ridx;
        chk("R7 free=16", almost_full, ((512 - (tot - 1)) <= 16));
        chk("R2 in_ready with room", in_ready, 1);
        rd_cycles(1);
        settle();
        tot = hist.size() - ridx;
        chk("R7 free=17", almost_full, ((512 - (tot - 1)) <= 16));

        // R6: almost-empty threshold edges (ae_level = 8 words)
        n = (hist.size() - ridx) - 9;
        rd_cycles(n);
        settle();
        tot = hist.size() - ridx;
        chk("R6 count=9", almost_empty, (tot <= 8));
        rd_cycles(1);
        settle();
        tot = hist.size() - ridx;
        chk("R6 count=8", almost_empty, (tot <= 8));
        drain("R5 drained after flag walk");

        // R8/R9: mark, read ahead, rewind
        base = hist.size();
        wr_cycles(5);
        settle();
        chk("R3 ready before mark", out_ready, 1);
        @(posedge rclk); #2;
        mark_en = 1'b1;
        rd_cycles(3);
        settle();
        chk("R8 read ahead of mark", rd_data, hist[base + 3]);
        @(posedge rclk); #2;
        rewind = 1'b1;
        rd_en  = 1'b1;
        @(posedge rclk); #1;
        chk("R9 rewind shows marked word", rd_data, hist[base]);
        chk("R9 ready after rewind", out_ready, 1);
        #1;
        rewind = 1'b0;
        rd_en  = 1'b0;
        rd_cycles(1);
        @(negedge rclk);
        chk("R9 continues after mark", rd_data, hist[base + 1]);

        // R10: writer stops at the protected region
        wr_cycles(520);
        settle();
        chk("R10 accepted while marked", hist.size() - base - 5, 508);
        chk("R10 in_ready low at mark", in_ready, 0);
        @(posedge rclk); #2;
        mark_en = 1'b0;
        drain("R8 replay then drain");
        chk("R10 room after release", in_ready, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge wclk);
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule